// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block steps a processor into and out of interrupt and fault handlers. When a request is accepted it stalls the datapath, writes the program counter to the stack and then writes each internal register, one word per cycle. It then loads the counter with the handler start address, which it reads from the vector table slot that belongs to the winning source.

A single return command undoes the entry. The saved registers are popped in the reverse of the order they were pushed, and the counter is popped last. The watchdog works differently because the program it interrupted is taken to be hung. On return from the watchdog handler no word is popped. The stack pointer is reloaded with the value it held before entry, which throws the saved context away, and the counter is loaded from the reset slot of the vector table.

The stack unit, the vector table and the register file all sit outside the block. The block drives their push, pop, pointer-load and write-back ports.

Top module: `irq_ctx_seq`

## Requirements
- R1: On the cycle after the clock edge that accepts a request, `active` rises and the block pushes `pc_cur`. This is the first push of the entry.
- R2: In the NREG cycles after the counter push, the block pushes the registers in ascending index order, one per cycle with no gaps. Register k is `reg_cur[k*DW +: DW]`.
- R3: On the cycle after the last push, `pc_load` is high and `pc_load_val` equals `vec_rdata` for the slot shown on `vec_slot`.
- R4: Each source has a fixed vector slot: reset 0, non-maskable 1, watchdog 2, fault i at 3+i, timer at 3+NFLT. When several requests are pending, the winner is non-maskable first, then watchdog, then faults with the lower index first, then timer.
- R5: While `active` is high no request is accepted. A request that is still held when the return finishes is accepted after exactly one idle cycle.
- R6: For a non-watchdog source, in the NREG+1 cycles after a return command is sampled, `stk_pop` is high on every cycle. The first NREG cycles write back registers NREG-1 down to 0 through `reg_load`, `reg_load_idx` and `reg_load_val` = `stk_rdata`. The last cycle drives `pc_load` with `stk_rdata`.
- R7: For a watchdog source, the cycle after the return command is sampled has no pop. On that cycle `sp_load` is high with the `stk_sp` value captured at acceptance, `pc_load` is high with `vec_slot` = 0, and `pc_load_val` = `vec_rdata`.
- R8: During reset and right after it, all strobes (`active`, `stk_push`, `stk_pop`, `pc_load`, `sp_load`, `reg_load`) are low.
- R9: `active` stays high from the first push through the last restore cycle and goes low on the next cycle.
- R10: A return command is ignored unless the handler is running. If it arrives while idle or during the save sequence, it produces no pop and no counter load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_nmi | input | 1 | Non-maskable request (level) |
| req_wdt | input | 1 | Watchdog request (level) |
| req_fault | input | NFLT | Fault requests, bit 0 highest priority |
| req_tmr | input | 1 | Periodic timer request (level) |
| ret_cmd | input | 1 | Return-from-handler command |
| pc_cur | input | DW | Live program counter |
| reg_cur | input | NREG*DW | Live internal registers, packed |
| stk_sp | input | SPW | Current stack pointer |
| stk_rdata | input | DW | Top-of-stack word |
| vec_rdata | input | DW | Vector table word for `vec_slot` |
| active | output | 1 | Sequence or handler in progress; stalls the datapath |
| stk_push | output | 1 | Push `stk_wdata` |
| stk_pop | output | 1 | Pop top of stack |
| stk_wdata | output | DW | Word to push |
| sp_load | output | 1 | Reload stack pointer |
| sp_load_val | output | SPW | Stack pointer reload value |
| vec_slot | output | clog2(NFLT+4) | Vector table slot being read |
| pc_load | output | 1 | Load program counter |
| pc_load_val | output | DW | Program counter load value |
| reg_load | output | 1 | Write back one register |
| reg_load_idx | output | clog2(NREG) | Index of register written back |
| reg_load_val | output | DW | Register write-back value |

## Verification
Every result has a fixed cycle relative to the clock edge that samples its stimulus. The counter push comes one cycle after the accepting edge, register k is pushed k+1 cycles after the counter, and the vector load follows NREG+2 cycles after acceptance. Restore pops, or the single watchdog discard cycle, start on the cycle right after the edge that samples the return command. The bench drives inputs and samples outputs on falling edges, and advances exactly one falling edge per expected cycle, so each check looks at exactly the cycle in which its result is due. It sweeps all 31 non-empty request patterns, computes the winning slot and the handler address with arithmetic, and models the stack so that it can check the pointer once each return has finished.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_VECT,
    ST_RUN,
    ST_REST,
    ST_DROP
  } ctx_state_e;

  // Fixed vector slot numbers; the fault slots follow SLOT_FLT0, then timer.
  localparam int unsigned SLOT_RST  = 0;
  localparam int unsigned SLOT_NMI  = 1;
  localparam int unsigned SLOT_WDT  = 2;
  localparam int unsigned SLOT_FLT0 = 3;

endpackage

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb
  import irq_ctx_pkg::*;
#(
  parameter int unsigned NFLT = 2,
  parameter int unsigned SLW  = 3
) (
  input  logic            req_nmi,
  input  logic            req_wdt,
  input  logic [NFLT-1:0] req_fault,
  input  logic            req_tmr,
  output logic            any_req,
  output logic [SLW-1:0]  win_slot
);

  localparam int unsigned SLOT_TMR = SLOT_FLT0 + NFLT;

  // Per-fault slot numbers, one per fault line.
  logic [SLW-1:0] flt_slot [NFLT];

  genvar g;
  generate
    for (g = 0; g < NFLT; g++) begin : g_flt
      assign flt_slot[g] = SLW'(SLOT_FLT0 + g);
    end
  endgenerate

  assign any_req = req_nmi | req_wdt | (|req_fault) | req_tmr;

  // Lowest priority first, so that later assignments override earlier ones.
  always_comb begin
    win_slot = SLW'(SLOT_TMR);
    for (int i = NFLT - 1; i >= 0; i--) begin
      if (req_fault[i]) win_slot = flt_slot[i];
    end
    if (req_wdt) win_slot = SLW'(SLOT_WDT);
    if (req_nmi) win_slot = SLW'(SLOT_NMI);
  end

endmodule

// File: rtl/irq_ctx_wsel.sv
module irq_ctx_wsel #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4,
  parameter int unsigned CW   = 3
) (
  input  logic [DW-1:0]      pc_cur,
  input  logic [NREG*DW-1:0] reg_cur,
  input  logic [CW-1:0]      step,
  output logic [DW-1:0]      push_word
);

  // Save order: word 0 is the counter, word k+1 is register k.
  logic [DW-1:0] words [NREG+1];

  assign words[0] = pc_cur;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      assign words[g+1] = reg_cur[g*DW +: DW];
    end
  endgenerate

  always_comb begin
    push_word = '0;
    for (int i = 0; i <= NREG; i++) begin
      if (step == CW'(i)) push_word = words[i];
    end
  end

endmodule

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4,
  parameter int unsigned SPW  = 8,
  parameter int unsigned SLW  = 3,
  parameter int unsigned RIW  = 2,
  parameter int unsigned CW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_req,
  input  logic [SLW-1:0] win_slot,
  input  logic           ret_cmd,
  input  logic [SPW-1:0] stk_sp,
  input  logic [DW-1:0]  stk_rdata,
  input  logic [DW-1:0]  vec_rdata,
  input  logic [DW-1:0]  push_word,
  input  logic [DW-1:0]  pc_cur,
  output logic [CW-1:0]  step,
  output logic           active,
  output logic           stk_push,
  output logic           stk_pop,
  output logic [DW-1:0]  stk_wdata,
  output logic           sp_load,
  output logic [SPW-1:0] sp_load_val,
  output logic [SLW-1:0] vec_slot,
  output logic           pc_load,
  output logic [DW-1:0]  pc_load_val,
  output logic           reg_load,
  output logic [RIW-1:0] reg_load_idx,
  output logic [DW-1:0]  reg_load_val
);

  localparam logic [CW-1:0] LAST = CW'(NREG);

  ctx_state_e     state_q, state_d;
  logic [CW-1:0]  step_q, step_d;
  logic [SLW-1:0] slot_q;
  logic [SPW-1:0] sp_q;
  logic           cap_en;
  logic           is_wdt;
  logic [CW-1:0]  ridx_full;

  assign cap_en = (state_q == ST_IDLE) && any_req;
  assign is_wdt = (slot_q == SLW'(SLOT_WDT));

  // Next-state process
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      ST_IDLE: begin
        if (any_req) begin
          state_d = ST_SAVE;
          step_d  = '0;
        end
      end
      ST_SAVE: begin
        if (step_q == LAST) begin
          state_d = ST_VECT;
          step_d  = '0;
        end else begin
          step_d = step_q + CW'(1);
        end
      end
      ST_VECT: state_d = ST_RUN;
      ST_RUN: begin
        if (ret_cmd) begin
          state_d = is_wdt ? ST_DROP : ST_REST;
          step_d  = '0;
        end
      end
      ST_REST: begin
        if (step_q == LAST) begin
          state_d = ST_IDLE;
          step_d  = '0;
        end else begin
          step_d = step_q + CW'(1);
        end
      end
      ST_DROP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      slot_q  <= '0;
      sp_q    <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (cap_en) begin
        slot_q <= win_slot;
        sp_q   <= stk_sp;
      end
    end
  end

  // Output decode
  assign step      = step_q;
  assign active    = (state_q != ST_IDLE);
  assign stk_push  = (state_q == ST_SAVE);
  assign stk_wdata = stk_push ? push_word : '0;
  assign stk_pop   = (state_q == ST_REST);

  assign ridx_full    = LAST - step_q - CW'(1);
  assign reg_load     = stk_pop && (step_q != LAST);
  assign reg_load_idx = reg_load ? RIW'(ridx_full) : '0;
  assign reg_load_val = reg_load ? stk_rdata : '0;

  assign sp_load     = (state_q == ST_DROP);
  assign sp_load_val = sp_load ? sp_q : '0;

  assign vec_slot = (state_q == ST_VECT) ? slot_q : SLW'(SLOT_RST);

  always_comb begin
    pc_load     = 1'b0;
    pc_load_val = '0;
    if (state_q == ST_VECT || state_q == ST_DROP) begin
      pc_load     = 1'b1;
      pc_load_val = vec_rdata;
    end else if (stk_pop && step_q == LAST) begin
      pc_load     = 1'b1;
      pc_load_val = stk_rdata;
    end
  end

  // Word counters used only by the properties below
  logic [CW:0] push_cnt, pop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_cnt <= '0;
      pop_cnt  <= '0;
    end else if (!active) begin
      push_cnt <= '0;
      pop_cnt  <= '0;
    end else begin
      if (stk_push) push_cnt <= push_cnt + 1'b1;
      if (stk_pop)  pop_cnt  <= pop_cnt + 1'b1;
    end
  end

  AST_ENTRY_PC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (stk_push && stk_wdata == pc_cur)); // R1

  AST_ENTRY_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !stk_pop && !sp_load) |-> (push_cnt == (CW+1)'(NREG + 1))); // R2

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(slot_q)); // R5

  AST_RESTORE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && stk_pop) |-> (pop_cnt == (CW+1)'(NREG) && push_cnt == (CW+1)'(NREG + 1))); // R6

  AST_POP_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_load && $past(reg_load)) |-> (reg_load_idx == $past(reg_load_idx) - 1'b1)); // R6

  AST_WDT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> (pc_load && !stk_pop && vec_slot == '0 && pop_cnt == '0)); // R7

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4,
  parameter int unsigned NFLT = 2,
  parameter int unsigned SPW  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_nmi,
  input  logic                      req_wdt,
  input  logic [NFLT-1:0]           req_fault,
  input  logic                      req_tmr,
  input  logic                      ret_cmd,
  input  logic [DW-1:0]             pc_cur,
  input  logic [NREG*DW-1:0]        reg_cur,
  input  logic [SPW-1:0]            stk_sp,
  input  logic [DW-1:0]             stk_rdata,
  input  logic [DW-1:0]             vec_rdata,
  output logic                      active,
  output logic                      stk_push,
  output logic                      stk_pop,
  output logic [DW-1:0]             stk_wdata,
  output logic                      sp_load,
  output logic [SPW-1:0]            sp_load_val,
  output logic [$clog2(NFLT+4)-1:0] vec_slot,
  output logic                      pc_load,
  output logic [DW-1:0]             pc_load_val,
  output logic                      reg_load,
  output logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] reg_load_idx,
  output logic [DW-1:0]             reg_load_val
);

  localparam int unsigned SLW = $clog2(NFLT + 4);
  localparam int unsigned RIW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int unsigned CW  = $clog2(NREG + 1);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic           any_req;
  logic [SLW-1:0] win_slot;
  logic [CW-1:0]  step;
  logic [DW-1:0]  push_word;

  irq_ctx_arb #(
    .NFLT (NFLT),
    .SLW  (SLW)
  ) u_arb (
    .req_nmi   (req_nmi),
    .req_wdt   (req_wdt),
    .req_fault (req_fault),
    .req_tmr   (req_tmr),
    .any_req   (any_req),
    .win_slot  (win_slot)
  );

  irq_ctx_wsel #(
    .DW   (DW),
    .NREG (NREG),
    .CW   (CW)
  ) u_wsel (
    .pc_cur    (pc_cur),
    .reg_cur   (reg_cur),
    .step      (step),
    .push_word (push_word)
  );

  irq_ctx_ctrl #(
    .DW   (DW),
    .NREG (NREG),
    .SPW  (SPW),
    .SLW  (SLW),
    .RIW  (RIW),
    .CW   (CW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync),
    .any_req      (any_req),
    .win_slot     (win_slot),
    .ret_cmd      (ret_cmd),
    .stk_sp       (stk_sp),
    .stk_rdata    (stk_rdata),
    .vec_rdata    (vec_rdata),
    .push_word    (push_word),
    .pc_cur       (pc_cur),
    .step         (step),
    .active       (active),
    .stk_push     (stk_push),
    .stk_pop      (stk_pop),
    .stk_wdata    (stk_wdata),
    .sp_load      (sp_load),
    .sp_load_val  (sp_load_val),
    .vec_slot     (vec_slot),
    .pc_load      (pc_load),
    .pc_load_val  (pc_load_val),
    .reg_load     (reg_load),
    .reg_load_idx (reg_load_idx),
    .reg_load_val (reg_load_val)
  );

endmodule

// File: tb/irq_ctx_seq_tb.sv
`timescale 1ns/1ps
module irq_ctx_seq_tb;

  localparam int NREG = 4;
  localparam int NFLT = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_nmi, req_wdt, req_tmr, ret_cmd;
  logic [1:0]      req_fault;
  logic [15:0]     pc_cur;
  logic [63:0]     reg_cur;
  logic [7:0]      stk_sp;
  logic [15:0]     stk_rdata, vec_rdata;
  logic            active, stk_push, stk_pop, sp_load, pc_load, reg_load;
  logic [15:0]     stk_wdata, pc_load_val, reg_load_val;
  logic [7:0]      sp_load_val;
  logic [2:0]      vec_slot;
  logic [1:0]      reg_load_idx;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #4 clk = ~clk;

  irq_ctx_seq #(.DW(16), .NREG(NREG), .NFLT(NFLT), .SPW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_nmi(req_nmi), .req_wdt(req_wdt),
    .req_fault(req_fault), .req_tmr(req_tmr), .ret_cmd(ret_cmd),
    .pc_cur(pc_cur), .reg_cur(reg_cur), .stk_sp(stk_sp),
    .stk_rdata(stk_rdata), .vec_rdata(vec_rdata), .active(active),
    .stk_push(stk_push), .stk_pop(stk_pop), .stk_wdata(stk_wdata),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .vec_slot(vec_slot),
    .pc_load(pc_load), .pc_load_val(pc_load_val), .reg_load(reg_load),
    .reg_load_idx(reg_load_idx), .reg_load_val(reg_load_val)
  );

  // Stack model: grows downward, top word at sp+1.
  logic [15:0] stk_mem [256];
  logic [7:0]  sp;

  always_ff @(posedge clk) if (stk_push) stk_mem[sp] <= stk_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sp <= 8'hF0;
    else if (sp_load)  sp <= sp_load_val;
    else if (stk_push) sp <= sp - 8'd1;
    else if (stk_pop)  sp <= sp + 8'd1;
  end

  assign stk_sp    = sp;
  assign stk_rdata = stk_mem[sp + 8'd1];
  assign vec_rdata = vec_of(vec_slot);

  function automatic logic [15:0] vec_of(input logic [2:0] s);
    return 16'h0200 + (16'(s) << 4);
  endfunction

  function automatic logic [15:0] regv(input logic [15:0] p, input int k);
    return p ^ (16'h1111 * 16'(k + 1));
  endfunction

  function automatic logic [2:0] prio(input logic [4:0] m);
    if (m[0]) return 3'd1;
    if (m[1]) return 3'd2;
    if (m[2]) return 3'd3;
    if (m[3]) return 3'd4;
    return 3'd5;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  logic [15:0] sav_pc;
  logic [7:0]  sp0;
  logic [2:0]  exp_slot;

  task automatic enter(input logic [4:0] m, input logic [15:0] pcv, input bit early);
    sav_pc   = pcv;
    sp0      = sp;
    exp_slot = prio(m);
    pc_cur   = pcv;
    for (int k = 0; k < NREG; k++) reg_cur[k*16 +: 16] = regv(pcv, k);
    req_nmi   = m[0];
    req_wdt   = m[1];
    req_fault = m[3:2];
    req_tmr   = m[4];
    @(negedge clk);
    chk(active && stk_push && stk_wdata == pcv, "R1", {15'd0, stk_push, stk_wdata}, {16'd1, pcv});
    req_nmi = 0; req_wdt = 0; req_fault = '0; req_tmr = 0;
    if (early) ret_cmd = 1'b1;
    for (int k = 0; k < NREG; k++) begin
      @(negedge clk);
      chk(stk_push && !pc_load && stk_wdata == regv(pcv, k), "R2", {16'd0, stk_wdata}, {16'd0, regv(pcv, k)});
      ret_cmd = 1'b0;
    end
    @(negedge clk);
    chk(pc_load && !stk_push && vec_slot == exp_slot, "R4", {28'd0, pc_load, vec_slot}, {28'd1, exp_slot});
    chk(pc_load_val == vec_of(exp_slot), "R3", {16'd0, pc_load_val}, {16'd0, vec_of(exp_slot)});
    if (early) chk(!stk_pop && active, "R10", {31'd0, stk_pop}, 32'd0);
  endtask

  task automatic leave();
    pc_cur  = 16'hDEAD;
    reg_cur = {4{16'hBEEF}};
    @(negedge clk);
    chk(active && !stk_push && !pc_load && !stk_pop, "R9", {29'd0, active, stk_push, pc_load}, 32'h4);
    ret_cmd = 1'b1;
    @(negedge clk);
    ret_cmd = 1'b0;
    if (exp_slot == 3'd2) begin
      chk(sp_load && sp_load_val == sp0, "R7", {23'd0, sp_load, sp_load_val}, {23'd1, sp0});
      chk(pc_load && vec_slot == 3'd0 && pc_load_val == vec_of(3'd0) && !stk_pop, "R7",
          {16'd0, pc_load_val}, {16'd0, vec_of(3'd0)});
      @(negedge clk);
      chk(!active, "R9", {31'd0, active}, 32'd0);
      chk(sp == sp0, "R7", {24'd0, sp}, {24'd0, sp0});
    end else begin
      for (int k = 0; k < NREG; k++) begin
        chk(stk_pop && reg_load && !pc_load && int'(reg_load_idx) == NREG - 1 - k, "R6",
            {30'd0, reg_load_idx}, 32'(NREG - 1 - k));
        chk(reg_load_val == regv(sav_pc, NREG - 1 - k), "R6", {16'd0, reg_load_val},
            {16'd0, regv(sav_pc, NREG - 1 - k)});
        @(negedge clk);
      end
      chk(stk_pop && pc_load && !reg_load && pc_load_val == sav_pc, "R6", {16'd0, pc_load_val}, {16'd0, sav_pc});
      @(negedge clk);
      chk(!active && !stk_pop, "R9", {30'd0, active, stk_pop}, 32'd0);
      chk(sp == sp0, "R6", {24'd0, sp}, {24'd0, sp0});
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired (cycle %0d)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_nmi = 0; req_wdt = 0; req_fault = '0; req_tmr = 0; ret_cmd = 0;
    pc_cur = '0; reg_cur = '0;
    repeat (4) @(negedge clk);
    chk(!active && !stk_push && !stk_pop && !pc_load && !sp_load && !reg_load, "R8",
        {26'd0, active, stk_push, stk_pop, pc_load, sp_load, reg_load}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!active && !stk_push && !stk_pop && !pc_load && !sp_load && !reg_load, "R8",
        {26'd0, active, stk_push, stk_pop, pc_load, sp_load, reg_load}, 32'd0);

    // R10: return while idle does nothing
    ret_cmd = 1'b1;
    @(negedge clk);
    ret_cmd = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(!active && !stk_pop && !pc_load && !sp_load, "R10", {29'd0, active, stk_pop, pc_load}, 32'd0);
      @(negedge clk);
    end

    // R4 sweep over every non-empty request pattern
    for (int m = 1; m < 32; m++) begin
      enter(5'(m), 16'h1000 + 16'(m * 37), (m % 3) == 0);
      leave();
    end

    // R5: request during handler is held off, then taken after one idle cycle
    enter(5'b10000, 16'h4321, 1'b0);
    req_nmi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(active && !stk_push && !pc_load, "R5", {30'd0, stk_push, pc_load}, 32'd0);
    end
    leave();
    enter(5'b00001, 16'h5A5A, 1'b0);
    leave();

    // Watchdog with a fault pending at the same time
    enter(5'b00110, 16'h7777, 1'b0);
    leave();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule